// File: doc/BRIEF.md
# Segmented Virtual Address Formation Unit

This unit widens a 32-bit effective address into a 40-bit virtual address. A file of sixteen 12-bit segment identifiers sits beside the address path. The top four bits of each incoming effective address pick one identifier. That identifier then replaces those four bits above the untouched 28-bit offset. Every segment therefore covers 256 MB, and 4096 distinct segments fit into a 1 TB virtual space.

Requests arrive on a valid/ready channel and results leave on a second valid/ready channel after one registered stage. Software loads identifiers through a write port, one index per clock. It can inspect any identifier through a combinational read port. Physical translation, caching of translations and access protection happen downstream and are not part of this unit.

Top module: `seg_vaddr_unit`

## Requirements
- R1: While reset is asserted and after its release, `rsp_valid_o` is 0, `req_ready_o` is 1, and every segment register reads 0.
- R2: Bits [27:0] of `rsp_va_o` equal bits [27:0] of the effective address of the accepted request.
- R3: Bits [39:28] of `rsp_va_o` equal the segment register whose index is bits [31:28] of the accepted effective address.
- R4: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both 1. Its response is presented with `rsp_valid_o` high directly after that edge.
- R5: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, `rsp_valid_o` and `rsp_va_o` stay unchanged.
- R6: `req_ready_o` is 0 exactly when a response is stalled (`rsp_valid_o` 1 and `rsp_ready_i` 0). A request offered while a response is stalled is not taken.
- R7: A write with `wr_en_i` high stores `wr_sid_i` into register `wr_idx_i` at the rising edge. No other register changes.
- R8: A translation accepted in the same cycle as a write to its index uses the value the register held before that write.
- R9: `rd_sid_o` returns register `rd_idx_i` combinationally, without waiting for a clock edge.
- R10: With `rsp_ready_i` held at 1, a new request is accepted on every cycle, one response per cycle in order.
- R11: When a response is consumed and no new request is accepted, `rsp_valid_o` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Effective address is valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_ea_i | input | 32 | Effective address |
| rsp_valid_o | output | 1 | Virtual address is valid |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_va_o | output | 40 | Formed virtual address |
| wr_en_i | input | 1 | Segment register write enable |
| wr_idx_i | input | 4 | Segment register written |
| wr_sid_i | input | 12 | Identifier to write |
| rd_idx_i | input | 4 | Segment register inspected |
| rd_sid_o | output | 12 | Identifier at `rd_idx_i` |

## Verification
A segment register write and a translation that selects the same register can land on one clock edge. The bench provokes this by raising the write enable and a request whose top bits name the written index in the same cycle. It judges the response against the old identifier. It then checks through the read port and a follow-up request that the new value was stored. A second overlap, where a response is released and a new request is taken on the same edge, is driven under random stalls and checked against an in-order expected queue.

// File: rtl/seg_vaddr_pkg.sv
`timescale 1ns/1ps
package seg_vaddr_pkg;
  localparam int unsigned EA_W_DEF  = 32;
  localparam int unsigned SEL_W_DEF = 4;
  localparam int unsigned SID_W_DEF = 12;
endpackage

// File: rtl/seg_id_file.sv
`timescale 1ns/1ps
module seg_id_file #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned SID_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] widx_i,
  input  logic [SID_W-1:0] wdata_i,
  input  logic [SEL_W-1:0] xidx_i,
  output logic [SID_W-1:0] xdata_o,
  input  logic [SEL_W-1:0] ridx_i,
  output logic [SID_W-1:0] rdata_o
);
  localparam int unsigned NSEG = 1 << SEL_W;

  logic [NSEG-1:0][SID_W-1:0] sid_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SID_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (we_i && widx_i == SEL_W'(g))       q <= wdata_i;
    end
    assign sid_q[g] = q;
  end

  // translation read and software read are independent ports
  assign xdata_o = sid_q[xidx_i];
  assign rdata_o = sid_q[ridx_i];
endmodule

// File: rtl/va_compose.sv
`timescale 1ns/1ps
module va_compose #(
  parameter int unsigned EA_W  = 32,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned SID_W = 12
) (
  input  logic [EA_W-1:0]               ea_i,
  input  logic [SID_W-1:0]              sid_i,
  output logic [SEL_W-1:0]              sel_o,
  output logic [SID_W+EA_W-SEL_W-1:0]   va_o
);
  localparam int unsigned OFF_W = EA_W - SEL_W;

  assign sel_o = ea_i[EA_W-1 -: SEL_W];
  assign va_o  = {sid_i, ea_i[OFF_W-1:0]};
endmodule

// File: rtl/va_out_stage.sv
`timescale 1ns/1ps
module va_out_stage #(
  parameter int unsigned DW = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  // stall blocks intake; consumption frees the slot in the same cycle
  assign in_ready_o = !valid_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_valid_i && in_ready_o) begin
      valid_q <= 1'b1;
      data_q  <= in_data_i;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/seg_vaddr_unit.sv
`timescale 1ns/1ps
module seg_vaddr_unit
  import seg_vaddr_pkg::*;
#(
  parameter int unsigned EA_W  = EA_W_DEF,
  parameter int unsigned SEL_W = SEL_W_DEF,
  parameter int unsigned SID_W = SID_W_DEF,
  localparam int unsigned VA_W = SID_W + EA_W - SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [EA_W-1:0]  req_ea_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [VA_W-1:0]  rsp_va_o,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_idx_i,
  input  logic [SID_W-1:0] wr_sid_i,
  input  logic [SEL_W-1:0] rd_idx_i,
  output logic [SID_W-1:0] rd_sid_o
);
  logic [SEL_W-1:0] sel;
  logic [SID_W-1:0] sid;
  logic [VA_W-1:0]  va;

  seg_id_file #(.SEL_W(SEL_W), .SID_W(SID_W)) u_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .widx_i  (wr_idx_i),
    .wdata_i (wr_sid_i),
    .xidx_i  (sel),
    .xdata_o (sid),
    .ridx_i  (rd_idx_i),
    .rdata_o (rd_sid_o)
  );

  va_compose #(.EA_W(EA_W), .SEL_W(SEL_W), .SID_W(SID_W)) u_comp (
    .ea_i  (req_ea_i),
    .sid_i (sid),
    .sel_o (sel),
    .va_o  (va)
  );

  va_out_stage #(.DW(VA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (va),
    .out_valid_o (rsp_valid_o),
    .out_ready_i (rsp_ready_i),
    .out_data_o  (rsp_va_o)
  );
endmodule

// File: rtl/seg_vaddr_chk.sv
`timescale 1ns/1ps
module seg_vaddr_chk #(
  parameter int unsigned EA_W  = 32,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned SID_W = 12,
  localparam int unsigned OFF_W = EA_W - SEL_W,
  localparam int unsigned VA_W  = SID_W + OFF_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [EA_W-1:0] req_ea_i,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [VA_W-1:0] rsp_va_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_idle_in_reset: assert (!rsp_valid_o && req_ready_o);
  end

  a_r2_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_va_o[OFF_W-1:0] == $past(req_ea_i[OFF_W-1:0]));

  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_va_o)));

  a_r6_no_take_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o);

  a_r11_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i && !req_valid_i) |=> !rsp_valid_o);
endmodule

bind seg_vaddr_unit seg_vaddr_chk #(.EA_W(EA_W), .SEL_W(SEL_W), .SID_W(SID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_ea_i    (req_ea_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_va_o    (rsp_va_o)
);

// File: tb/seg_vaddr_unit_tb.sv
`timescale 1ns/1ps
module seg_vaddr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_ea_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [39:0] rsp_va_o;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [11:0] wr_sid_i = '0;
  logic [3:0]  rd_idx_i = '0;
  logic [11:0] rd_sid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [11:0] model [16];

  always #5 clk = ~clk;

  seg_vaddr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_ea_i(req_ea_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_va_o(rsp_va_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_sid_i(wr_sid_i),
    .rd_idx_i(rd_idx_i), .rd_sid_o(rd_sid_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] ref_va(input logic [31:0] ea);
    return {model[ea[31:28]], ea[27:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic write_sid(input logic [3:0] idx, input logic [11:0] val);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_sid_i = val;
    @(negedge clk);
    wr_en_i = 1'b0;
    model[idx] = val;
  endtask

  // R1
  task automatic t_reset();
    chk("R1 rsp_valid", 64'(rsp_valid_o), 64'd0);
    chk("R1 req_ready", 64'(req_ready_o), 64'd1);
    for (int i = 0; i < 16; i++) begin
      rd_idx_i = 4'(i); #1;
      chk("R1 sid zero", 64'(rd_sid_o), 64'd0);
    end
  endtask

  // R7, R9
  task automatic t_write_read();
    for (int i = 0; i < 16; i++) write_sid(4'(i), 12'($urandom));
    for (int i = 15; i >= 0; i--) begin
      rd_idx_i = 4'(i); #1;
      chk("R9 comb read / R7 stored", 64'(rd_sid_o), 64'(model[i]));
    end
    write_sid(4'd9, ~model[9]);
    for (int i = 0; i < 16; i++) begin
      rd_idx_i = 4'(i); #1;
      chk("R7 single index written", 64'(rd_sid_o), 64'(model[i]));
    end
  endtask

  // R2, R3, R4, R11
  task automatic t_basic();
    logic [31:0] pats [6] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0FFF_FFFF, 32'h5A5A_A5A5, 32'h3123_4567};
    foreach (pats[k]) begin
      @(negedge clk);
      req_valid_i = 1'b1; req_ea_i = pats[k]; rsp_ready_i = 1'b1;
      @(negedge clk);
      req_valid_i = 1'b0;
      chk("R4 valid after accept", 64'(rsp_valid_o), 64'd1);
      chk("R2 offset", 64'(rsp_va_o[27:0]), 64'(pats[k][27:0]));
      chk("R3 segment id", 64'(rsp_va_o[39:28]), 64'(model[pats[k][31:28]]));
      @(negedge clk);
      chk("R11 valid falls", 64'(rsp_valid_o), 64'd0);
    end
  endtask

  // R8
  task automatic t_same_cycle();
    logic [11:0] oldv = model[5];
    logic [11:0] newv = ~model[5];
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 4'd5; wr_sid_i = newv;
    req_valid_i = 1'b1; req_ea_i = 32'h5ABC_DEF0; rsp_ready_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; req_valid_i = 1'b0;
    chk("R8 old value used", 64'(rsp_va_o), 64'({oldv, 28'hABC_DEF0}));
    model[5] = newv;
    rd_idx_i = 4'd5; #1;
    chk("R8 new value stored", 64'(rd_sid_o), 64'(newv));
    @(negedge clk);
    req_valid_i = 1'b1; req_ea_i = 32'h5000_0001;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R8 next request sees new", 64'(rsp_va_o), 64'({newv, 28'h000_0001}));
    @(negedge clk);
  endtask

  // R5, R6
  task automatic t_stall();
    logic [39:0] held;
    @(negedge clk);
    req_valid_i = 1'b1; req_ea_i = 32'hC111_2222; rsp_ready_i = 1'b0;
    @(negedge clk);
    held = rsp_va_o;
    chk("R5 first response", 64'(held), 64'(ref_va(32'hC111_2222)));
    req_ea_i = 32'h7333_4444;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R6 ready low on stall", 64'(req_ready_o), 64'd0);
      @(negedge clk);
      chk("R5 valid held", 64'(rsp_valid_o), 64'd1);
      chk("R5 data held", 64'(rsp_va_o), 64'(held));
    end
    rsp_ready_i = 1'b1; #1;
    chk("R6 ready back", 64'(req_ready_o), 64'd1);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R6 blocked request taken later", 64'(rsp_va_o), 64'(ref_va(32'h7333_4444)));
    @(negedge clk);
  endtask

  // R10, R2, R3 under back-to-back and random stalls
  task automatic t_random(input int n, input bit stalls);
    logic [39:0] q [$];
    int accepted = 0;
    int cycles = 0;
    while (accepted < n || q.size() != 0) begin
      @(negedge clk);
      req_valid_i = (accepted < n) && (stalls ? ($urandom_range(0, 3) != 0) : 1'b1);
      req_ea_i = $urandom;
      rsp_ready_i = stalls ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (rsp_valid_o && rsp_ready_i) begin
        if (q.size() == 0) chk("R10 unexpected response", 64'(rsp_va_o), 64'd0);
        else chk(stalls ? "R2/R3 stalled stream" : "R10 back-to-back", 64'(rsp_va_o), 64'(q.pop_front()));
      end
      if (req_valid_i && req_ready_o) begin
        q.push_back(ref_va(req_ea_i));
        accepted++;
      end
      cycles++;
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    if (!stalls) chk("R10 one per cycle", 64'(cycles), 64'(n + 1));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_basic();
    t_same_cycle();
    t_stall();
    t_random(64, 1'b0);
    t_random(300, 1'b1);
    finish_run();
  end
endmodule